// File: doc/BRIEF.md
# Tamper Event Timestamp Capture

This block watches an external active-low tamper pin. When that pin falls, it takes a copy of the live calendar. The calendar arrives as six BCD fields: seconds, minutes, hours, day of month, month and year. The block keeps that copy in read-only registers so that software can read it later. Each event sets two event flags, which sit in two different control bytes. A maskable active-low interrupt stays asserted while either flag is set.

A control byte has two bits. One turns the timestamp function off. The other picks what happens to the snapshot when later events arrive:

- Latest-event mode: every event overwrites the stored copy.
- First-event mode: the stored copy is frozen until software has cleared both flags.

Flags are cleared by writing zero to their bit positions. The calendar counter and the serial bus that carries register accesses are outside this block. The register port is a plain single-cycle write strobe with a shared address, and read data is registered.

Top module: `ts_stamp_top`

## Requirements
- R1: After a synchronous reset, the following hold:
  - the flags, the interrupt enable, the disable bit, the mode bit and all six snapshot registers read 0;
  - `irq_n` is 1.
- R2: `tamper_n` passes through a two-stage synchronizer and only its falling edge is an event.
  - An event updates the flags and the snapshot at the third rising clock edge after `tamper_n` is first seen low.
  - Holding the pin low produces exactly one event.
- R3: The snapshot samples all six calendar fields in the same cycle. Each field keeps only its valid bits and reads 0 in the others:
  - seconds and minutes: bits 6:0;
  - hours and day: bits 5:0;
  - month: bits 4:0;
  - year: bits 7:0.
- R4: An accepted event sets both flags: flag A is bit 4 of address 0x00, and flag B is bit 5 of address 0x01.
- R5: While the disable bit (bit 6 of address 0x12) is 1, events neither set flags nor change the snapshot.
- R6: While the mode bit (bit 7 of 0x12) is 1 and either flag is set, events leave the snapshot unchanged but still set the flags.
- R7: While the mode bit is 0, every enabled event overwrites the snapshot.
- R8: Writing a 0 to bit 4 of 0x00 clears flag A, and writing a 0 to bit 5 of 0x01 clears flag B. Writing a 1 to either bit leaves that flag unchanged. A write to 0x01 also loads the interrupt enable from bit 2.
- R9: `irq_n` is 0 exactly one cycle after the interrupt enable is 1 while a flag is set; otherwise it is 1.
- R10: `reg_rdata` shows the byte at `reg_addr` one clock later. The snapshot registers sit at 0x13 to 0x18 in the order seconds, minutes, hours, day, month, year. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_n | input | 1 | Asynchronous active-low tamper pin |
| cal_sec | input | 8 | Live BCD seconds |
| cal_min | input | 8 | Live BCD minutes |
| cal_hour | input | 8 | Live BCD hours |
| cal_day | input | 8 | Live BCD day of month |
| cal_mon | input | 8 | Live BCD month, 1 to 12 |
| cal_year | input | 8 | Live BCD year |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 5 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
The assertions check the following on every cycle:
- the interrupt follows enable and flags with a one-cycle lag;
- the snapshot stays frozen while first-event mode holds or the function is disabled;
- an event sets both flags;
- an event lasts a single cycle;
- the unused seconds bit stays 0.

Some behaviour can only be shown by the bench's scenarios:
- the three-edge latency from the pin;
- that a sampled snapshot carries the calendar value that was present;
- re-arming after both flags are cleared;
- that writing ones does not clear a flag;
- that a long low pulse gives only one event.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int DW = 8;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_FLAGA = 5'h00;
  localparam logic [AW-1:0] A_FLAGB = 5'h01;
  localparam logic [AW-1:0] A_CTRL  = 5'h12;
  localparam logic [AW-1:0] A_SNAP0 = 5'h13;
  localparam int NFIELD = 6;

  localparam int BIT_FA   = 4;
  localparam int BIT_FB   = 5;
  localparam int BIT_IE   = 2;
  localparam int BIT_OFF  = 6;
  localparam int BIT_MODE = 7;

  typedef struct packed {
    logic [DW-1:0] sec;
    logic [DW-1:0] min;
    logic [DW-1:0] hour;
    logic [DW-1:0] day;
    logic [DW-1:0] mon;
    logic [DW-1:0] year;
  } ts_time_t;

  function automatic ts_time_t trim(input ts_time_t t);
    ts_time_t r;
    r.sec  = t.sec  & 8'h7F;
    r.min  = t.min  & 8'h7F;
    r.hour = t.hour & 8'h3F;
    r.day  = t.day  & 8'h3F;
    r.mon  = t.mon  & 8'h1F;
    r.year = t.year;
    return r;
  endfunction
endpackage

// File: rtl/ts_edge.sv
module ts_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], pin_n};
  end

  assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/ts_snapshot.sv
module ts_snapshot
  import ts_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cap,
  input  ts_time_t live,
  output ts_time_t snap
);
  always_ff @(posedge clk) begin
    if (rst)      snap <= '0;
    else if (cap) snap <= trim(live);
  end
endmodule

// File: rtl/ts_ctrl.sv
module ts_ctrl
  import ts_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ev,
  output logic          fa,
  output logic          fb,
  output logic          ie,
  output logic          off,
  output logic          first,
  output logic          cap,
  output logic          irq_n
);
  logic fa_d, fb_d;
  logic accept;

  assign accept = ev & ~off;
  assign cap    = accept & ~(first & (fa | fb));

  always_comb begin
    fa_d = fa;
    fb_d = fb;
    if (wr && addr == A_FLAGA && !wdata[BIT_FA]) fa_d = 1'b0;
    if (wr && addr == A_FLAGB && !wdata[BIT_FB]) fb_d = 1'b0;
    if (accept) begin
      fa_d = 1'b1;
      fb_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fa    <= 1'b0;
      fb    <= 1'b0;
      ie    <= 1'b0;
      off   <= 1'b0;
      first <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      fa    <= fa_d;
      fb    <= fb_d;
      irq_n <= ~(ie & (fa | fb));
      if (wr && addr == A_FLAGB) ie <= wdata[BIT_IE];
      if (wr && addr == A_CTRL) begin
        off   <= wdata[BIT_OFF];
        first <= wdata[BIT_MODE];
      end
    end
  end
endmodule

// File: rtl/ts_stamp_top.sv
module ts_stamp_top
  import ts_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tamper_n,
  input  logic [DW-1:0] cal_sec,
  input  logic [DW-1:0] cal_min,
  input  logic [DW-1:0] cal_hour,
  input  logic [DW-1:0] cal_day,
  input  logic [DW-1:0] cal_mon,
  input  logic [DW-1:0] cal_year,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  logic     ev, cap, fa, fb, ie, off, first;
  ts_time_t live, snap;
  logic [DW-1:0] fields [NFIELD];

  assign live = '{sec: cal_sec, min: cal_min, hour: cal_hour,
                  day: cal_day, mon: cal_mon, year: cal_year};

  ts_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst(rst), .pin_n(tamper_n), .fall(ev)
  );

  ts_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ev(ev), .fa(fa), .fb(fb), .ie(ie), .off(off), .first(first),
    .cap(cap), .irq_n(irq_n)
  );

  ts_snapshot u_snap (
    .clk(clk), .rst(rst), .cap(cap), .live(live), .snap(snap)
  );

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
      assign fields[i] = snap[(NFIELD-1-i)*DW +: DW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_addr == A_FLAGA)
        reg_rdata[BIT_FA] <= fa;
      else if (reg_addr == A_FLAGB) begin
        reg_rdata[BIT_FB] <= fb;
        reg_rdata[BIT_IE] <= ie;
      end else if (reg_addr == A_CTRL) begin
        reg_rdata[BIT_OFF]  <= off;
        reg_rdata[BIT_MODE] <= first;
      end else if (reg_addr >= A_SNAP0 && reg_addr < A_SNAP0 + AW'(NFIELD))
        reg_rdata <= fields[reg_addr - A_SNAP0];
    end
  end
endmodule

// File: rtl/ts_stamp_chk.sv
module ts_stamp_chk
  import ts_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     ev,
  input logic     fa,
  input logic     fb,
  input logic     ie,
  input logic     off,
  input logic     first,
  input logic     irq_n,
  input ts_time_t snap
);
  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (rst)
    (ie && (fa || fb)) |=> !irq_n);                          // R9
  AST_IRQ_HIGH: assert property (@(posedge clk) disable iff (rst)
    !(ie && (fa || fb)) |=> irq_n);                          // R9
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (first && (fa || fb)) |=> $stable(snap));                // R6
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    off |=> $stable(snap));                                  // R5
  AST_OFF_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (off && !fa) |=> !fa);                                   // R5
  AST_EV_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (ev && !off) |=> (fa && fb));                            // R4
  AST_EV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);                                             // R2
  AST_SEC_TRIM: assert property (@(posedge clk) disable iff (rst)
    !snap.sec[7]);                                           // R3
endmodule

bind ts_stamp_top ts_stamp_chk u_chk (
  .clk(clk), .rst(rst), .ev(ev), .fa(fa), .fb(fb), .ie(ie),
  .off(off), .first(first), .irq_n(irq_n), .snap(snap)
);

// File: tb/tb_ts_stamp_top.sv
module tb_ts_stamp_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // {first_mode, clear_before, raw sec..year, expected sec..year}
  localparam logic [97:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 48'hD9D9E3F1F299, 48'h595923311299},
    {1'b0, 1'b0, 48'h000000010100, 48'h000000010100},
    {1'b1, 1'b0, 48'h123410150624, 48'h000000010100},
    {1'b1, 1'b1, 48'h123410150624, 48'h123410150624}
  };

  logic clk = 0, rst = 1, tamper_n = 1, reg_wr = 0, irq_n;
  logic [7:0] cal [6];
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, rd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_stamp_top dut (
    .clk(clk), .rst(rst), .tamper_n(tamper_n),
    .cal_sec(cal[0]), .cal_min(cal[1]), .cal_hour(cal[2]),
    .cal_day(cal[3]), .cal_mon(cal[4]), .cal_year(cal[5]),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic set_cal(input logic [47:0] v);
    for (int i = 0; i < 6; i++) cal[i] = v[(5-i)*8 +: 8];
  endtask

  task automatic pulse();
    @(negedge clk); tamper_n = 0;
    repeat (4) @(negedge clk);
    tamper_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_snap(input string req, input logic [47:0] exp);
    for (int i = 0; i < 6; i++) begin
      rdreg(5'h13 + 5'(i), rd);
      chk(req, rd, exp[(5-i)*8 +: 8]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    set_cal(48'h0);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rdreg(5'h00, rd); chk("R1 flagA byte", rd, 8'h00);
    rdreg(5'h01, rd); chk("R1 flagB byte", rd, 8'h00);
    rdreg(5'h12, rd); chk("R1 ctrl byte", rd, 8'h00);
    rdreg(5'h13, rd); chk("R1 snapshot", rd, 8'h00);
    chk("R1 irq_n", irq_n, 1'b1);

    // R2 / R9 latency: the flag lands on edge 3 and irq_n follows on edge 4
    wr(5'h01, 8'h04);
    set_cal(48'h300000010100);
    @(negedge clk); tamper_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 irq_n before event", irq_n, 1'b1);
    @(negedge clk);
    chk("R9 irq_n asserted", irq_n, 1'b0);
    tamper_n = 1;
    repeat (4) @(negedge clk);
    rdreg(5'h13, rd); chk("R2 captured sec", rd, 8'h30);

    // table of vectors: R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      wr(5'h12, {VEC[v][97], 7'b0});
      if (VEC[v][96]) begin wr(5'h00, 8'h00); wr(5'h01, 8'h04); end
      set_cal(VEC[v][95:48]);
      pulse();
      chk_snap(VEC[v][97] ? "R6 first-mode snapshot" : "R7 R3 latest snapshot", VEC[v][47:0]);
      rdreg(5'h00, rd); chk("R4 flag A", rd, 8'h10);
      rdreg(5'h01, rd); chk("R4 flag B", rd, 8'h24);
    end

    // R8: writing 1 does not clear, writing 0 does
    wr(5'h00, 8'hFF);
    rdreg(5'h00, rd); chk("R8 write one keeps flag A", rd, 8'h10);
    wr(5'h00, 8'h00);
    rdreg(5'h00, rd); chk("R8 write zero clears flag A", rd, 8'h00);
    // R6: flag B alone still holds the snapshot
    set_cal(48'h555555151155);
    pulse();
    chk_snap("R6 held by one flag", 48'h123410150624);
    wr(5'h00, 8'h00); wr(5'h01, 8'h04);
    repeat (2) @(negedge clk);
    chk("R9 irq_n released", irq_n, 1'b1);

    // R5: disabled function
    wr(5'h12, 8'h40);
    pulse();
    rdreg(5'h00, rd); chk("R5 no flag when off", rd, 8'h00);
    rdreg(5'h13, rd); chk("R5 no capture when off", rd, 8'h12);
    rdreg(5'h12, rd); chk("R10 ctrl readback", rd, 8'h40);

    // R2: a long low level gives one event only
    wr(5'h12, 8'h00);
    @(negedge clk); tamper_n = 0;
    repeat (6) @(negedge clk);
    wr(5'h00, 8'h00); wr(5'h01, 8'h04);
    repeat (6) @(negedge clk);
    rdreg(5'h00, rd); chk("R2 single event on held low", rd, 8'h00);
    tamper_n = 1;
    repeat (4) @(negedge clk);
    rdreg(5'h13, rd); chk("R2 R7 capture on that event", rd, 8'h55);

    // R9: interrupt masked
    pulse();
    wr(5'h01, 8'h20);
    repeat (2) @(negedge clk);
    chk("R9 irq_n masked", irq_n, 1'b1);
    rdreg(5'h01, rd); chk("R8 flag B kept by write one", rd, 8'h20);

    // R10: unmapped address
    rdreg(5'h05, rd); chk("R10 unmapped reads zero", rd, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule